// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block steps a small processor core into and back out of an interrupt handler. It holds the core's code segment, instruction pointer, flag word and stack pointer. It also drives a 16-bit word memory port that reaches two spaces: the stack and a low vector window.

A start strobe comes with an 8-bit vector type. The block then saves the old flag word, code segment and instruction pointer on the stack, in that order. It clears the trap and interrupt-enable bits and fetches the handler's pointer pair from the vector window. A return strobe undoes the save: it pops the instruction pointer, then the code segment, then the flag word, and the trap bit comes back if it was saved set. While idle, the core can write its own code segment, instruction pointer and flags through a write strobe.

The memory port has one cycle of read latency. Read data that belongs to a request issued in one cycle is valid during the following cycle.

Top module: `int_entry_seq`

## Requirements
- R1: `busy_o` rises in the cycle after an accepted strobe. It stays high for exactly 6 cycles for an entry and exactly 4 cycles for a return. `mem_req_o` is high only while busy.
- R2: An entry writes three stack words in this order: the flag word as it was before clearing, then CS, then IP. Before each write SP drops by 2, wrapping modulo 2^16, and each write address equals the new SP.
- R3: From the first busy cycle of an entry, flag bits 8 (trap) and 9 (interrupt enable) read 0. All other flag bits keep their values.
- R4: After the pushes, an entry reads the vector space (`mem_stack_o`=0, `mem_we_o`=0) at byte address type*4 for the new IP and then at type*4+2 for the new CS. Every vector address lies below 0x400.
- R5: In the cycle in which `busy_o` falls after an entry, `cs_o` and `ip_o` show the two fetched words. They hold their old values through every busy cycle.
- R6: A return reads the stack at SP, SP+2 and SP+4, taking IP, CS and the flag word in that order. SP rises by 2 after each read. All three registers are restored together, a saved trap bit included.
- R7: Start, return and core-write strobes that arrive while busy have no effect.
- R8: A synchronous reset clears CS, IP, flags and the vector class to 0, drops busy and any memory request, and sets SP to `SP_RESET`.
- R9: `vec_class_o` takes the class of the accepted type and keeps it until the next entry: 0 for types 0 to 4, 1 for types 5 to 31, 2 for types 32 to 255.
- R10: In idle, start takes priority over return, and return takes priority over core write. A core write that is honoured loads CS, IP and flags on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an interrupt entry |
| vec_type_i | input | TYPE_W | Vector type number sampled with start |
| ret_i | input | 1 | Begin a return from handler |
| core_wr_i | input | 1 | Load CS, IP and flags from the core while idle |
| core_cs_i | input | DATA_W | Code segment value to load |
| core_ip_i | input | DATA_W | Instruction pointer value to load |
| core_flags_i | input | DATA_W | Flag word value to load |
| cs_o | output | DATA_W | Current code segment |
| ip_o | output | DATA_W | Current instruction pointer |
| flags_o | output | DATA_W | Current flag word |
| sp_o | output | DATA_W | Current stack pointer |
| busy_o | output | 1 | Sequence in progress |
| vec_class_o | output | 2 | Class of the last accepted type |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_stack_o | output | 1 | 1 = stack space, 0 = vector space |
| mem_addr_o | output | ADDR_W | Byte address of the word |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid the cycle after the read request |

## Verification
The bench uses the default widths: 16-bit words, a 20-bit address and an 8-bit type. With these, the whole 256-entry vector window can be reached, and the class edges at types 4/5 and 31/32 and the top type 255 can all be exercised. `SP_RESET` is set to 0x0006. Two nested entries then take SP down through zero to 0xFFFA, and the two returns must climb back across the same wrap to 0x0006.

// File: rtl/iseq_pkg.sv
`timescale 1ns/1ps
package iseq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PUSH_F,
    S_PUSH_CS,
    S_PUSH_IP,
    S_RD_IP,
    S_RD_CS,
    S_WAIT_E,
    S_POP_IP,
    S_POP_CS,
    S_POP_F,
    S_WAIT_R
  } seq_state_t;

  typedef enum logic [1:0] {
    VC_DEDICATED = 2'd0,
    VC_RESERVED  = 2'd1,
    VC_AVAILABLE = 2'd2
  } vec_class_t;

  function automatic logic is_push(seq_state_t s);
    return (s == S_PUSH_F) || (s == S_PUSH_CS) || (s == S_PUSH_IP);
  endfunction

  function automatic logic is_pop(seq_state_t s);
    return (s == S_POP_IP) || (s == S_POP_CS) || (s == S_POP_F);
  endfunction

endpackage

// File: rtl/iseq_fsm.sv
`timescale 1ns/1ps
module iseq_fsm
  import iseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       ret_i,
  output seq_state_t state_q,
  output seq_state_t state_d
);

  // Each non-idle state lasts exactly one cycle; start outranks return.
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (start_i)    state_d = S_PUSH_F;
        else if (ret_i) state_d = S_POP_IP;
      end
      S_PUSH_F:  state_d = S_PUSH_CS;
      S_PUSH_CS: state_d = S_PUSH_IP;
      S_PUSH_IP: state_d = S_RD_IP;
      S_RD_IP:   state_d = S_RD_CS;
      S_RD_CS:   state_d = S_WAIT_E;
      S_WAIT_E:  state_d = S_IDLE;
      S_POP_IP:  state_d = S_POP_CS;
      S_POP_CS:  state_d = S_POP_F;
      S_POP_F:   state_d = S_WAIT_R;
      S_WAIT_R:  state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_IDLE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/iseq_sp.sv
`timescale 1ns/1ps
module iseq_sp #(
  parameter int          SP_W     = 16,
  parameter logic [15:0] SP_RESET = 16'hFFFE
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dec_i,
  input  logic            inc_i,
  output logic [SP_W-1:0] sp_q,
  output logic [SP_W-1:0] sp_d
);

  localparam logic [SP_W-1:0] STEP = SP_W'(2);

  // Decrement lands on the edge entering a push; increment on the edge leaving a pop.
  always_comb begin
    sp_d = sp_q;
    if (dec_i)      sp_d = sp_q - STEP;
    else if (inc_i) sp_d = sp_q + STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) sp_q <= SP_W'(SP_RESET);
    else     sp_q <= sp_d;
  end

endmodule

// File: rtl/iseq_vec.sv
`timescale 1ns/1ps
module iseq_vec
  import iseq_pkg::*;
#(
  parameter int TYPE_W   = 8,
  parameter int ADDR_W   = 20,
  parameter int DED_LAST = 4,
  parameter int RES_LAST = 31
) (
  input  logic [TYPE_W-1:0] vec_type_i,
  output logic [ADDR_W-1:0] base_ip_o,
  output logic [ADDR_W-1:0] base_cs_o,
  output vec_class_t        class_o
);

  localparam int PAD_W = ADDR_W - TYPE_W - 2;

  // Entry base = type * 4; low word holds IP, high word holds CS.
  assign base_ip_o = {{PAD_W{1'b0}}, vec_type_i, 2'b00};
  assign base_cs_o = {{PAD_W{1'b0}}, vec_type_i, 2'b10};

  always_comb begin
    if (vec_type_i <= TYPE_W'(DED_LAST))      class_o = VC_DEDICATED;
    else if (vec_type_i <= TYPE_W'(RES_LAST)) class_o = VC_RESERVED;
    else                                      class_o = VC_AVAILABLE;
  end

endmodule

// File: rtl/int_entry_seq.sv
`timescale 1ns/1ps
module int_entry_seq
  import iseq_pkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int          ADDR_W   = 20,
  parameter int          TYPE_W   = 8,
  parameter int          TF_BIT   = 8,
  parameter int          IF_BIT   = 9,
  parameter int          DED_LAST = 4,
  parameter int          RES_LAST = 31,
  parameter logic [15:0] SP_RESET = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [TYPE_W-1:0] vec_type_i,
  input  logic              ret_i,
  input  logic              core_wr_i,
  input  logic [DATA_W-1:0] core_cs_i,
  input  logic [DATA_W-1:0] core_ip_i,
  input  logic [DATA_W-1:0] core_flags_i,
  output logic [DATA_W-1:0] cs_o,
  output logic [DATA_W-1:0] ip_o,
  output logic [DATA_W-1:0] flags_o,
  output logic [DATA_W-1:0] sp_o,
  output logic              busy_o,
  output logic [1:0]        vec_class_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_stack_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  localparam logic [DATA_W-1:0] CLR_MASK =
    (DATA_W'(1) << TF_BIT) | (DATA_W'(1) << IF_BIT);
  localparam int SP_PAD = ADDR_W - DATA_W;

  seq_state_t state_q, state_d;
  logic [DATA_W-1:0] sp_q, sp_d;
  logic [ADDR_W-1:0] vb_ip, vb_cs, vb_ip_q, vb_cs_q, stack_addr;
  vec_class_t        vclass, class_q;
  logic [DATA_W-1:0] cs_q, ip_q, flags_q, tmp_ip_q, tmp_cs_q;
  logic              busy_q;
  logic              req_d, we_d, stk_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wd_d;
  logic              req_q, we_q, stk_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q;

  iseq_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .ret_i   (ret_i),
    .state_q (state_q),
    .state_d (state_d)
  );

  iseq_sp #(
    .SP_W     (DATA_W),
    .SP_RESET (SP_RESET)
  ) u_sp (
    .clk   (clk),
    .rst   (rst),
    .dec_i (is_push(state_d)),
    .inc_i (is_pop(state_q)),
    .sp_q  (sp_q),
    .sp_d  (sp_d)
  );

  iseq_vec #(
    .TYPE_W   (TYPE_W),
    .ADDR_W   (ADDR_W),
    .DED_LAST (DED_LAST),
    .RES_LAST (RES_LAST)
  ) u_vec (
    .vec_type_i (vec_type_i),
    .base_ip_o  (vb_ip),
    .base_cs_o  (vb_cs),
    .class_o    (vclass)
  );

  assign stack_addr = {{SP_PAD{1'b0}}, sp_d};

  // Next bus word, decoded from the state being entered, then registered.
  always_comb begin
    req_d  = 1'b0;
    we_d   = 1'b0;
    stk_d  = 1'b0;
    addr_d = '0;
    wd_d   = '0;
    unique case (state_d)
      S_PUSH_F: begin
        req_d = 1'b1; we_d = 1'b1; stk_d = 1'b1;
        addr_d = stack_addr; wd_d = flags_q;
      end
      S_PUSH_CS: begin
        req_d = 1'b1; we_d = 1'b1; stk_d = 1'b1;
        addr_d = stack_addr; wd_d = cs_q;
      end
      S_PUSH_IP: begin
        req_d = 1'b1; we_d = 1'b1; stk_d = 1'b1;
        addr_d = stack_addr; wd_d = ip_q;
      end
      S_RD_IP: begin
        req_d = 1'b1; addr_d = vb_ip_q;
      end
      S_RD_CS: begin
        req_d = 1'b1; addr_d = vb_cs_q;
      end
      S_POP_IP, S_POP_CS, S_POP_F: begin
        req_d = 1'b1; stk_d = 1'b1; addr_d = stack_addr;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      we_q   <= 1'b0;
      stk_q  <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      busy_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      we_q   <= we_d;
      stk_q  <= stk_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
      busy_q <= (state_d != S_IDLE);
    end
  end

  // Architectural registers and the capture of read data one cycle after each read.
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q     <= '0;
      ip_q     <= '0;
      flags_q  <= '0;
      tmp_ip_q <= '0;
      tmp_cs_q <= '0;
      vb_ip_q  <= '0;
      vb_cs_q  <= '0;
      class_q  <= VC_DEDICATED;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (start_i) begin
            flags_q <= flags_q & ~CLR_MASK;
            vb_ip_q <= vb_ip;
            vb_cs_q <= vb_cs;
            class_q <= vclass;
          end else if (!ret_i && core_wr_i) begin
            cs_q    <= core_cs_i;
            ip_q    <= core_ip_i;
            flags_q <= core_flags_i;
          end
        end
        S_RD_CS:  tmp_ip_q <= mem_rdata_i;
        S_WAIT_E: begin
          ip_q <= tmp_ip_q;
          cs_q <= mem_rdata_i;
        end
        S_POP_CS: tmp_ip_q <= mem_rdata_i;
        S_POP_F:  tmp_cs_q <= mem_rdata_i;
        S_WAIT_R: begin
          ip_q    <= tmp_ip_q;
          cs_q    <= tmp_cs_q;
          flags_q <= mem_rdata_i;
        end
        default: ;
      endcase
    end
  end

  assign cs_o        = cs_q;
  assign ip_o        = ip_q;
  assign flags_o     = flags_q;
  assign sp_o        = sp_q;
  assign busy_o      = busy_q;
  assign vec_class_o = class_q;
  assign mem_req_o   = req_q;
  assign mem_we_o    = we_q;
  assign mem_stack_o = stk_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wd_q;

endmodule

// File: rtl/int_entry_seq_chk.sv
`timescale 1ns/1ps
module int_entry_seq_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 20,
  parameter int TYPE_W = 8,
  parameter int TF_BIT = 8,
  parameter int IF_BIT = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic [DATA_W-1:0] sp,
  input logic [DATA_W-1:0] cs,
  input logic [DATA_W-1:0] ip,
  input logic [DATA_W-1:0] flags,
  input logic [1:0]        vec_class,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_stack,
  input logic [ADDR_W-1:0] mem_addr
);

  localparam int VEC_BYTES = (1 << TYPE_W) * 4;

  assert_req_in_busy_R1: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  assert_stack_addr_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_stack) |-> (mem_addr == {{(ADDR_W-DATA_W){1'b0}}, sp}));

  assert_push_step_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (sp == DATA_W'($past(sp) - DATA_W'(2))));

  assert_flags_clear_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && mem_we) |-> (!flags[TF_BIT] && !flags[IF_BIT]));

  assert_vec_window_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_stack) |-> (!mem_we && (mem_addr < ADDR_W'(VEC_BYTES))));

  assert_hold_while_busy_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($stable(cs) && $stable(ip)));

  assert_class_code_R9: assert property (@(posedge clk) disable iff (rst)
    vec_class != 2'd3);

endmodule

bind int_entry_seq int_entry_seq_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .TYPE_W (TYPE_W),
  .TF_BIT (TF_BIT),
  .IF_BIT (IF_BIT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy_o),
  .sp        (sp_o),
  .cs        (cs_o),
  .ip        (ip_o),
  .flags     (flags_o),
  .vec_class (vec_class_o),
  .mem_req   (mem_req_o),
  .mem_we    (mem_we_o),
  .mem_stack (mem_stack_o),
  .mem_addr  (mem_addr_o)
);

// File: tb/int_entry_seq_test.sv
`timescale 1ns/1ps
module int_entry_seq_test;

  localparam logic [15:0] SP_RST = 16'h0006;
  localparam logic [15:0] CLR    = 16'h0300;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, ret = 1'b0, core_wr = 1'b0;
  logic [7:0]  vtype = '0;
  logic [15:0] c_cs = '0, c_ip = '0, c_fl = '0;
  logic [15:0] cs, ip, flags, sp, wdata, rdata = '0;
  logic [19:0] addr;
  logic [1:0]  vclass;
  logic        busy, req, we, stk;

  always #2.5 clk = ~clk;

  int_entry_seq #(.SP_RESET(SP_RST)) uut (
    .clk(clk), .rst(rst), .start_i(start), .vec_type_i(vtype), .ret_i(ret),
    .core_wr_i(core_wr), .core_cs_i(c_cs), .core_ip_i(c_ip), .core_flags_i(c_fl),
    .cs_o(cs), .ip_o(ip), .flags_o(flags), .sp_o(sp), .busy_o(busy),
    .vec_class_o(vclass), .mem_req_o(req), .mem_we_o(we), .mem_stack_o(stk),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_rdata_i(rdata)
  );

  int n_run = 0, n_fail = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] vip(logic [7:0] t);
    return {t ^ 8'hA5, t};
  endfunction
  function automatic logic [15:0] vcs(logic [7:0] t);
    return {8'h10 + t, 8'h3C ^ t};
  endfunction
  function automatic logic [1:0] cls_ref(logic [7:0] t);
    if (t <= 8'd4)  return 2'd0;
    if (t <= 8'd31) return 2'd1;
    return 2'd2;
  endfunction

  // Word memory with one cycle read latency; stack and vector spaces keyed apart.
  logic [15:0] mem [int];
  always @(posedge clk) begin
    if (req) begin
      int key;
      key = stk ? (32'h0010_0000 | int'(addr)) : int'(addr);
      if (we) mem[key] = wdata;
      else    rdata <= mem.exists(key) ? mem[key] : 16'h0000;
    end
  end

  // Behavioural reference: phase counter plus a stack queue.
  logic [15:0] m_cs, m_ip, m_fl, m_sp;
  logic [7:0]  m_type;
  logic [1:0]  m_cls;
  logic        m_busy;
  int          m_kind, m_ph;
  logic [15:0] stackq [$];
  logic        e_req, e_we, e_stk;
  logic [19:0] e_addr;
  logic [15:0] e_wd;
  bit          cmp_en = 1'b0;

  always @(posedge clk) begin
    e_req = 0; e_we = 0; e_stk = 0; e_addr = '0; e_wd = '0;
    if (rst) begin
      m_cs = 0; m_ip = 0; m_fl = 0; m_sp = SP_RST; m_cls = 0;
      m_kind = 0; m_ph = 0; m_type = 0; stackq.delete();
    end else if (m_kind == 0) begin
      if (start) begin
        m_kind = 1; m_ph = 1; m_type = vtype; m_cls = cls_ref(vtype);
        stackq.push_back(m_fl);
        m_sp = m_sp - 16'd2;
        e_req = 1; e_we = 1; e_stk = 1; e_addr = {4'h0, m_sp}; e_wd = m_fl;
        m_fl = m_fl & ~CLR;
      end else if (ret) begin
        m_kind = 2; m_ph = 1;
        e_req = 1; e_stk = 1; e_addr = {4'h0, m_sp};
      end else if (core_wr) begin
        m_cs = c_cs; m_ip = c_ip; m_fl = c_fl;
      end
    end else if (m_kind == 1) begin
      m_ph++;
      case (m_ph)
        2: begin stackq.push_back(m_cs); m_sp = m_sp - 16'd2;
                 e_req = 1; e_we = 1; e_stk = 1; e_addr = {4'h0, m_sp}; e_wd = m_cs; end
        3: begin stackq.push_back(m_ip); m_sp = m_sp - 16'd2;
                 e_req = 1; e_we = 1; e_stk = 1; e_addr = {4'h0, m_sp}; e_wd = m_ip; end
        4: begin e_req = 1; e_addr = 20'(m_type) * 4; end
        5: begin e_req = 1; e_addr = 20'(m_type) * 4 + 2; end
        6: ;
        default: begin m_ip = vip(m_type); m_cs = vcs(m_type); m_kind = 0; end
      endcase
    end else begin
      m_ph++;
      case (m_ph)
        2, 3: begin m_sp = m_sp + 16'd2; e_req = 1; e_stk = 1; e_addr = {4'h0, m_sp}; end
        4: m_sp = m_sp + 16'd2;
        default: begin
          m_ip = stackq.pop_back(); m_cs = stackq.pop_back(); m_fl = stackq.pop_back();
          m_kind = 0;
        end
      endcase
    end
    m_busy = (m_kind != 0);
  end

  always @(posedge clk) begin
    #1;
    if (cmp_en) begin
      chk("R1 busy", busy, m_busy);
      chk("R5 cs", cs, m_cs);
      chk("R5 ip", ip, m_ip);
      chk("R3 flags", flags, m_fl);
      chk("R2 sp", sp, m_sp);
      chk("R9 class", vclass, m_cls);
      chk("R1 mem_req", req, e_req);
      if (e_req) begin
        chk(e_stk ? (e_we ? "R2 push addr" : "R6 pop addr") : "R4 vector addr", addr, e_addr);
        chk("R4 space select", stk, e_stk);
        chk("R2 write enable", we, e_we);
        if (e_we) chk("R2 push data", wdata, e_wd);
      end
    end
  end

  task automatic drive(bit s, bit r, bit w, logic [7:0] t, logic [15:0] cc, logic [15:0] ii, logic [15:0] ff);
    start = s; ret = r; core_wr = w; vtype = t; c_cs = cc; c_ip = ii; c_fl = ff;
    @(negedge clk);
    start = 0; ret = 0; core_wr = 0;
  endtask

  task automatic settle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog expired: actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] edges [4];
    edges = '{8'd4, 8'd31, 8'd32, 8'd255};
    for (int t = 0; t < 256; t++) begin
      mem[t * 4]     = vip(8'(t));
      mem[t * 4 + 2] = vcs(8'(t));
    end
    repeat (3) @(negedge clk);
    chk("R8 reset cs", cs, 0);
    chk("R8 reset ip", ip, 0);
    chk("R8 reset flags", flags, 0);
    chk("R8 reset sp", sp, SP_RST);
    chk("R8 reset busy", busy, 0);
    chk("R8 reset mem_req", req, 0);
    chk("R8 reset class", vclass, 0);
    rst = 0; cmp_en = 1;

    drive(0, 0, 1, 8'd0, 16'h1234, 16'h5678, 16'h03D5);
    chk("R10 core write cs", cs, 16'h1234);
    chk("R10 core write flags", flags, 16'h03D5);

    drive(1, 0, 0, 8'd0, 0, 0, 0);
    settle();
    chk("R5 entry ip type 0", ip, vip(8'd0));
    chk("R3 trap and enable cleared", flags, 16'h00D5);
    chk("R2 sp after entry", sp, 16'h0000);

    drive(1, 0, 0, 8'd200, 0, 0, 0);
    drive(1, 0, 0, 8'd9, 0, 0, 0);
    drive(0, 1, 0, 8'd0, 0, 0, 0);
    drive(0, 0, 1, 8'd0, 16'hAAAA, 16'hBBBB, 16'hFFFF);
    settle();
    chk("R7 strobes ignored while busy cs", cs, vcs(8'd200));
    chk("R7 strobes ignored while busy ip", ip, vip(8'd200));
    chk("R2 sp wrapped", sp, 16'hFFFA);
    chk("R9 available class", vclass, 2'd2);

    drive(0, 1, 0, 8'd0, 0, 0, 0);
    settle();
    chk("R6 return ip", ip, vip(8'd0));
    chk("R6 return sp", sp, 16'h0000);
    drive(0, 1, 0, 8'd0, 0, 0, 0);
    settle();
    chk("R6 saved trap flag restored", flags, 16'h03D5);
    chk("R6 return cs", cs, 16'h1234);
    chk("R6 sp back at reset value", sp, SP_RST);

    drive(1, 1, 1, 8'd5, 16'hAAAA, 16'hBBBB, 16'h0000);
    settle();
    chk("R10 start wins", ip, vip(8'd5));
    chk("R9 reserved low edge", vclass, 2'd1);
    drive(0, 1, 1, 8'd0, 16'hBEEF, 16'hBEEF, 16'h0000);
    settle();
    chk("R10 return over core write", cs, 16'h1234);

    for (int k = 0; k < 4; k++) begin
      drive(1, 0, 0, edges[k], 0, 0, 0);
      settle();
      chk("R9 class at edge type", vclass, cls_ref(edges[k]));
      chk("R4 fetched cs", cs, vcs(edges[k]));
      drive(0, 1, 0, 8'd0, 0, 0, 0);
      settle();
    end
    chk("R6 final flags", flags, 16'h03D5);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule